// File: doc/BRIEF.md
# Per-Area External Bus Cycle Timer

This block sets the length of every external bus cycle from the address area being accessed. The address space is split into eight areas. An 8-bit cycle-mode register gives each area one bit. When the bit is clear, the area gets a short two-state cycle. When the bit is set, the area gets a three-state cycle that can be stretched. Two 8-bit wait registers (high and low) hold a 2-bit programmable wait count for each area, and these waits apply only in the three-state mode. Targets flagged as on-chip, and all accesses in single-chip operation, use a fixed cycle. Areas flagged as DRAM space also use a fixed cycle. Neither of these fixed cycles depends on the registers.

An address decoder outside the block raises a request with the area index and the two target flags. The block then steps a state index through the cycle, flags the inserted wait states and pulses a done strobe in the last state. A plain CPU port writes the three registers and reads them back combinationally. A hardware-standby input reloads the registers to their reset value. A software-standby input holds off new cycles and leaves the register contents alone.

Top module: `bus_state_timer`

## Requirements
- R1: After the asynchronous reset, and in the cycle after any cycle with `hw_stby_i` high, all three registers read 0xFF. Register writes made while `hw_stby_i` is high are dropped.
- R2: `reg_addr_i` selects the register: 0 is the cycle-mode register (bit n = area n), 1 is the high wait register and 2 is the low wait register. A write with `reg_we_i` high takes effect at the clock edge. `reg_rdata_o` shows the selected register in the same cycle. Address 3 reads 0, and writes to it are dropped.
- R3: An external access to an area whose cycle-mode bit is 0 lasts exactly 2 states, and `wait_o` stays low whatever that area's wait count is.
- R4: An external access to an area whose cycle-mode bit is 1 lasts 3 + w states, where w is that area's wait count. `wait_o` is high exactly at state indices 2 to 1 + w, which places the waits between the second state and the final state.
- R5: Area n's wait count is bits [2m+1:2m] of a wait register. For areas 0 to 3 the register is the low one with m = n. For areas 4 to 7 it is the high one with m = n - 4.
- R6: A request with `onchip_i` high lasts ONCHIP_STATES states (2 by default) with no waits, regardless of the registers and of `dram_i`.
- R7: A request with `dram_i` high and `onchip_i` low lasts DRAM_STATES states (4 by default) with no waits, regardless of that area's cycle-mode bit and wait count.
- R8: While `single_chip_i` is high, every request is handled as on-chip (R6). The registers stay writable and readable.
- R9: A request is taken at a rising edge when `busy_o` is low and both standby inputs are low. From the next cycle on, `busy_o` is high and `state_idx_o` counts 0, 1, 2, … one step per cycle. `done_o` is high for exactly one cycle, the final state. `busy_o` is low in the cycle after `done_o`, and a new request can be taken at the end of that cycle.
- R10: While `sw_stby_i` is high, no request is taken (`busy_o` stays low). The register contents are kept.
- R11: The cycle length and waits are fixed when the request is taken. Register writes made while a cycle runs affect only later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_stby_i | input | 1 | Hardware standby: reloads the registers and aborts any cycle |
| sw_stby_i | input | 1 | Software standby: blocks new cycles, keeps the registers |
| single_chip_i | input | 1 | Single-chip operation: every access treated as on-chip |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | DW (8) | Register write data |
| reg_rdata_o | output | DW (8) | Register read data (combinational) |
| req_i | input | 1 | Access request |
| area_i | input | log2(DW) (3) | Area index of the request |
| dram_i | input | 1 | Requested area is DRAM space |
| onchip_i | input | 1 | Target is on-chip memory or register |
| busy_o | output | 1 | Bus cycle in progress |
| state_idx_o | output | CW (3) | Index of the current state within the cycle |
| wait_o | output | 1 | Current state is an inserted wait |
| done_o | output | 1 | Final state of the cycle |

## Verification
A request taken at edge k shows up as state index 0 in the cycle after k. A cycle of N states raises `done_o` in the N-th cycle after k, and `busy_o` drops one cycle later. A register write at an edge is visible on the read port in the next cycle, with no extra delay, because reads are combinational. The bench drives every input on the falling edge and samples on the falling edge. A driver pushes the expected length and wait count for each request into a queue. A monitor pops the entry when state index 0 appears, then compares the state index and `wait_o` against it in every cycle until `done_o`. A cycle that is missing, or one that was never requested, is therefore reported at the exact cycle where it differs.

// File: rtl/bst_pkg.sv
package bst_pkg;
  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_WAIT_HI = 2'd1,
    SEL_WAIT_LO = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    KIND_ONCHIP = 2'd0,
    KIND_DRAM = 2'd1,
    KIND_TWO = 2'd2,
    KIND_THREE = 2'd3
  } cyc_kind_e;
endpackage

// File: rtl/bst_regs.sv
module bst_regs
  import bst_pkg::*;
#(
  parameter int DW = 8,
  parameter int WAIT_W = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 hw_stby_i,
  input  logic                 we_i,
  input  logic [1:0]           addr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  output logic [DW-1:0]        mode_o,
  output logic [2*DW-1:0]      waits_o
);
  logic [DW-1:0] mode_q, whi_q, wlo_q;
  reg_sel_e sel;

  assign sel = reg_sel_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '1;
      whi_q  <= '1;
      wlo_q  <= '1;
    end else if (hw_stby_i) begin
      mode_q <= '1;
      whi_q  <= '1;
      wlo_q  <= '1;
    end else if (we_i) begin
      case (sel)
        SEL_MODE:    mode_q <= wdata_i;
        SEL_WAIT_HI: whi_q  <= wdata_i;
        SEL_WAIT_LO: wlo_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_MODE:    rdata_o = mode_q;
      SEL_WAIT_HI: rdata_o = whi_q;
      SEL_WAIT_LO: rdata_o = wlo_q;
      default:     rdata_o = '0;
    endcase
  end

  assign mode_o  = mode_q;
  // low register carries the lower areas, fields ascending
  assign waits_o = {whi_q, wlo_q};
endmodule

// File: rtl/bst_plan.sv
module bst_plan
  import bst_pkg::*;
#(
  parameter int NUM_AREAS = 8,
  parameter int WAIT_W = 2,
  parameter int CW = 3,
  parameter int ONCHIP_STATES = 2,
  parameter int DRAM_STATES = 4,
  localparam int AREA_W = $clog2(NUM_AREAS)
) (
  input  logic [AREA_W-1:0]           area_i,
  input  logic                        dram_i,
  input  logic                        onchip_i,
  input  logic                        single_chip_i,
  input  logic [NUM_AREAS-1:0]        mode_i,
  input  logic [NUM_AREAS*WAIT_W-1:0] waits_i,
  output cyc_kind_e                   kind_o,
  output logic [CW-1:0]               last_o,
  output logic [WAIT_W-1:0]           nwait_o
);
  localparam logic [CW-1:0] ON_LAST = CW'(ONCHIP_STATES - 1);
  localparam logic [CW-1:0] DR_LAST = CW'(DRAM_STATES - 1);

  logic [WAIT_W-1:0] wfield [NUM_AREAS];

  for (genvar a = 0; a < NUM_AREAS; a++) begin : g_field
    assign wfield[a] = waits_i[a*WAIT_W +: WAIT_W];
  end

  always_comb begin
    nwait_o = '0;
    if (single_chip_i || onchip_i) begin
      kind_o = KIND_ONCHIP;
      last_o = ON_LAST;
    end else if (dram_i) begin
      kind_o = KIND_DRAM;
      last_o = DR_LAST;
    end else if (!mode_i[area_i]) begin
      kind_o = KIND_TWO;
      last_o = CW'(1);
    end else begin
      kind_o  = KIND_THREE;
      nwait_o = wfield[area_i];
      last_o  = CW'(2) + CW'(wfield[area_i]);
    end
  end
endmodule

// File: rtl/bst_seq.sv
module bst_seq
  import bst_pkg::*;
#(
  parameter int CW = 3,
  parameter int WAIT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_stby_i,
  input  logic              sw_stby_i,
  input  logic              req_i,
  input  cyc_kind_e         kind_i,
  input  logic [CW-1:0]     last_i,
  input  logic [WAIT_W-1:0] nwait_i,
  output logic              busy_o,
  output logic [CW-1:0]     idx_o,
  output logic              wait_o,
  output logic              done_o
);
  logic              busy_q;
  logic [CW-1:0]     idx_q, last_q, wait_end;
  logic [WAIT_W-1:0] nwait_q;
  cyc_kind_e         kind_q;
  logic              accept;

  assign accept = !busy_q && req_i && !sw_stby_i && !hw_stby_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      last_q  <= '0;
      nwait_q <= '0;
      kind_q  <= KIND_ONCHIP;
    end else if (hw_stby_i) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (accept) begin
      // plan frozen here; later register writes do not reach this cycle
      busy_q  <= 1'b1;
      idx_q   <= '0;
      last_q  <= last_i;
      nwait_q <= nwait_i;
      kind_q  <= kind_i;
    end else if (busy_q) begin
      if (idx_q == last_q) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign wait_end = CW'(2) + CW'(nwait_q);
  assign busy_o   = busy_q;
  assign idx_o    = idx_q;
  assign done_o   = busy_q && (idx_q == last_q);
  assign wait_o   = busy_q && (kind_q == KIND_THREE) &&
                    (idx_q >= CW'(2)) && (idx_q < wait_end);
endmodule

// File: rtl/bus_state_timer.sv
module bus_state_timer
  import bst_pkg::*;
#(
  parameter int DW = 8,
  parameter int ONCHIP_STATES = 2,
  parameter int DRAM_STATES = 4,
  localparam int AREA_W = $clog2(DW),
  localparam int WAIT_W = 2,
  localparam int EXT_MAX = 3 + (1 << WAIT_W) - 1,
  localparam int MAX_A = (EXT_MAX > DRAM_STATES) ? EXT_MAX : DRAM_STATES,
  localparam int MAX_LEN = (MAX_A > ONCHIP_STATES) ? MAX_A : ONCHIP_STATES,
  localparam int CW = $clog2(MAX_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_stby_i,
  input  logic              sw_stby_i,
  input  logic              single_chip_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic              req_i,
  input  logic [AREA_W-1:0] area_i,
  input  logic              dram_i,
  input  logic              onchip_i,
  output logic              busy_o,
  output logic [CW-1:0]     state_idx_o,
  output logic              wait_o,
  output logic              done_o
);
  logic [DW-1:0]     ast_q;
  logic [2*DW-1:0]   waits;
  cyc_kind_e         kind;
  logic [CW-1:0]     last;
  logic [WAIT_W-1:0] nwait;

  bst_regs #(.DW(DW), .WAIT_W(WAIT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hw_stby_i (hw_stby_i),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .mode_o    (ast_q),
    .waits_o   (waits)
  );

  bst_plan #(
    .NUM_AREAS(DW), .WAIT_W(WAIT_W), .CW(CW),
    .ONCHIP_STATES(ONCHIP_STATES), .DRAM_STATES(DRAM_STATES)
  ) u_plan (
    .area_i        (area_i),
    .dram_i        (dram_i),
    .onchip_i      (onchip_i),
    .single_chip_i (single_chip_i),
    .mode_i        (ast_q),
    .waits_i       (waits),
    .kind_o        (kind),
    .last_o        (last),
    .nwait_o       (nwait)
  );

  bst_seq #(.CW(CW), .WAIT_W(WAIT_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hw_stby_i (hw_stby_i),
    .sw_stby_i (sw_stby_i),
    .req_i     (req_i),
    .kind_i    (kind),
    .last_i    (last),
    .nwait_i   (nwait),
    .busy_o    (busy_o),
    .idx_o     (state_idx_o),
    .wait_o    (wait_o),
    .done_o    (done_o)
  );
endmodule

// File: rtl/bst_checker.sv
module bst_checker #(
  parameter int DW = 8,
  parameter int CW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          hw_stby_i,
  input logic          sw_stby_i,
  input logic          req_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          wait_o,
  input logic [CW-1:0] state_idx_o,
  input logic [DW-1:0] ast_q
);
  // R9
  done_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  // R9
  idle_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  // R9
  start_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i && !sw_stby_i && !hw_stby_i) |=> (busy_o && state_idx_o == '0));

  // R9
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && !hw_stby_i) |=>
      (busy_o && state_idx_o == $past(state_idx_o) + 1'b1));

  // R4
  wait_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_o |-> (busy_o && !done_o && state_idx_o >= CW'(2)));

  // R10
  sw_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_stby_i && !busy_o) |=> !busy_o);

  // R1
  stby_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_stby_i |=> (ast_q == '1));
endmodule

bind bus_state_timer bst_checker #(.DW(DW), .CW(CW)) u_bst_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hw_stby_i   (hw_stby_i),
  .sw_stby_i   (sw_stby_i),
  .req_i       (req_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .wait_o      (wait_o),
  .state_idx_o (state_idx_o),
  .ast_q       (ast_q)
);

// File: tb/bus_state_timer_tb_top.sv
`timescale 1ns/1ps
module bus_state_timer_tb_top;
  localparam int ON_LEN = 2;
  localparam int DR_LEN = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_stby = 1'b0, sw_stby = 1'b0, single_chip = 1'b0;
  logic we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic req = 1'b0;
  logic [2:0] area = 3'd0;
  logic dram = 1'b0, onchip = 1'b0;
  logic busy, wt, done;
  logic [2:0] sidx;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 1'b0;

  logic [7:0] m_mode = 8'hFF, m_whi = 8'hFF, m_wlo = 8'hFF;

  int    q_len[$];
  int    q_nw[$];
  string q_tag[$];

  always #4 clk = ~clk;

  bus_state_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hw_stby_i(hw_stby), .sw_stby_i(sw_stby),
    .single_chip_i(single_chip), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .req_i(req), .area_i(area),
    .dram_i(dram), .onchip_i(onchip), .busy_o(busy), .state_idx_o(sidx),
    .wait_o(wt), .done_o(done)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int wfield(input int a);
    logic [15:0] w;
    w = {m_whi, m_wlo};
    return int'(w[a*2 +: 2]);
  endfunction

  // monitor / scoreboard
  bit cur_act = 1'b0;
  int cur_len, cur_nw, cur_i;
  string cur_tag;
  bit wbad;

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !cur_act) begin
        if (q_len.size() == 0) begin
          chk(1'b0, "R9 unexpected cycle", 1, 0);
        end else begin
          cur_len = q_len.pop_front();
          cur_nw  = q_nw.pop_front();
          cur_tag = q_tag.pop_front();
          cur_act = 1'b1;
          cur_i   = 0;
          wbad    = 1'b0;
        end
      end
      if (cur_act) begin
        if (int'(sidx) != cur_i) wbad = 1'b1;
        if (wt != ((cur_i >= 2) && (cur_i < 2 + cur_nw))) wbad = 1'b1;
        if (done) begin
          chk(cur_i + 1 == cur_len, {cur_tag, " length"}, cur_i + 1, cur_len);
          chk(!wbad, {cur_tag, " wait/index pattern"}, int'(wbad), 0);
          cur_act = 1'b0;
        end else begin
          cur_i++;
          if (cur_i > 16) begin
            chk(1'b0, {cur_tag, " no done"}, cur_i, cur_len);
            cur_act = 1'b0;
          end
        end
      end
    end
  end

  task automatic push_exp(input int a, input bit d, input bit oc, input string tag);
    int len, nw;
    nw = 0;
    if (single_chip || oc) len = ON_LEN;
    else if (d) len = DR_LEN;
    else if (!m_mode[a]) len = 2;
    else begin nw = wfield(a); len = 3 + nw; end
    q_len.push_back(len);
    q_nw.push_back(nw);
    q_tag.push_back(tag);
  endtask

  task automatic start_acc(input int a, input bit d, input bit oc, input string tag);
    @(negedge clk);
    while (busy) @(negedge clk);
    push_exp(a, d, oc, tag);
    req = 1'b1; area = 3'(a); dram = d; onchip = oc;
    @(negedge clk);
    req = 1'b0; dram = 1'b0; onchip = 1'b0;
    chk(busy && sidx == 3'd0, "R9 start", int'(busy), 1);
  endtask

  task automatic finish_acc();
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(!busy, "R9 idle after done", int'(busy), 0);
  endtask

  task automatic access(input int a, input bit d, input bit oc, input string tag);
    start_acc(a, d, oc, tag);
    finish_acc();
  endtask

  task automatic wr(input logic [1:0] ad, input logic [7:0] v);
    @(negedge clk);
    we = 1'b1; addr = ad; wdata = v;
    @(negedge clk);
    we = 1'b0;
    case (ad)
      2'd0: m_mode = v;
      2'd1: m_whi = v;
      2'd2: m_wlo = v;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [1:0] ad, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = ad;
    #1;
    chk(rdata == exp, tag, int'(rdata), int'(exp));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 100000 && !finished) begin
      finished = 1'b1;
      failures++;
      $display("FAIL R9 watchdog actual=%0d expected=<100000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !wt, "R1 idle at reset", int'(busy), 0);
    rst_n = 1'b1;
    rd(2'd0, 8'hFF, "R1 mode reset");
    rd(2'd1, 8'hFF, "R1 wait hi reset");
    rd(2'd2, 8'hFF, "R1 wait lo reset");
    rd(2'd3, 8'h00, "R2 unused addr reads 0");

    // defaults: three-state, 3 waits
    access(5, 1'b0, 1'b0, "R4 default area5");

    wr(2'd0, 8'h0F);
    wr(2'd1, 8'hE4);
    wr(2'd2, 8'h1B);
    wr(2'd3, 8'h55);
    rd(2'd0, 8'h0F, "R2 mode readback");
    rd(2'd1, 8'hE4, "R2 wait hi readback");
    rd(2'd2, 8'h1B, "R2 wait lo readback");
    rd(2'd3, 8'h00, "R2 unused addr write dropped");

    for (int a = 0; a < 4; a++) access(a, 1'b0, 1'b0, "R4 R5 three-state area");
    for (int a = 4; a < 8; a++) access(a, 1'b0, 1'b0, "R3 two-state area");

    access(0, 1'b0, 1'b1, "R6 on-chip");
    access(1, 1'b1, 1'b1, "R6 on-chip over dram");
    access(0, 1'b1, 1'b0, "R7 dram three-state area");
    access(6, 1'b1, 1'b0, "R7 dram two-state area");

    single_chip = 1'b1;
    access(0, 1'b0, 1'b0, "R8 single-chip area0");
    access(2, 1'b1, 1'b0, "R8 single-chip dram");
    wr(2'd1, 8'h5A);
    rd(2'd1, 8'h5A, "R8 reg write in single-chip");
    single_chip = 1'b0;

    // software standby blocks requests, keeps registers
    @(negedge clk);
    sw_stby = 1'b1; req = 1'b1; area = 3'd0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!busy, "R10 request blocked", int'(busy), 0);
    end
    sw_stby = 1'b0; req = 1'b0;
    rd(2'd0, m_mode, "R10 mode kept");
    rd(2'd1, m_whi, "R10 wait hi kept");
    rd(2'd2, m_wlo, "R10 wait lo kept");

    // hardware standby reloads, write during it dropped
    @(negedge clk);
    hw_stby = 1'b1; we = 1'b1; addr = 2'd0; wdata = 8'h00;
    @(negedge clk);
    hw_stby = 1'b0; we = 1'b0;
    m_mode = 8'hFF; m_whi = 8'hFF; m_wlo = 8'hFF;
    rd(2'd0, 8'hFF, "R1 mode after hw standby");
    rd(2'd1, 8'hFF, "R1 wait hi after hw standby");
    rd(2'd2, 8'hFF, "R1 wait lo after hw standby");

    // register change during a cycle
    start_acc(3, 1'b0, 1'b0, "R11 in-flight keeps plan");
    @(negedge clk);
    we = 1'b1; addr = 2'd0; wdata = 8'h00;
    @(negedge clk);
    we = 1'b0; m_mode = 8'h00;
    finish_acc();
    access(3, 1'b0, 1'b0, "R11 next cycle uses new mode");

    // zero-wait three-state
    wr(2'd0, 8'h01);
    wr(2'd2, 8'hFC);
    access(0, 1'b0, 1'b0, "R4 zero waits");

    repeat (4) @(negedge clk);
    chk(q_len.size() == 0 && !cur_act, "R9 all cycles seen", q_len.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule